// File: doc/BRIEF.md
# Fetch Fault Tag Tracker

This block follows a fault mark raised by instruction fetch as the instruction moves through a decode slot and an execute slot. The mark is attached when the instruction loads into decode. No exception is raised at that point. The block raises the exception only when the marked instruction is in execute and the execute stage reports that it completed. If a taken branch flushes the decode slot, or the execute slot is overwritten before its occupant completes, the mark is dropped without any trace.

A breakpoint opcode uses the same path as a fetch fault. When halting debug is enabled, a breakpoint that completes in execute produces a debug-entry pulse instead of an abort pulse. Each pulse comes with a return address equal to the faulting address plus four. The surrounding pipeline drives the stage-advance, completion and flush strobes.

The execute slot is a four-state machine. `EX_EMPTY` means the slot holds nothing. `EX_CLEAN` means it holds an unmarked instruction. `EX_FAULT` means it holds a fetch-faulted instruction. `EX_BRK` means it holds a breakpoint.

The machine has two kinds of transition. *Complete* (`ex_go`) moves any occupied state to `EX_EMPTY`. *Load* (`ex_load` without `flush`) moves any state to the class of the decode slot: `EX_EMPTY` if decode is empty, `EX_FAULT` if the fault flag is set (the fault flag has priority), `EX_BRK` if only the breakpoint flag is set, and `EX_CLEAN` otherwise. When both happen in the same cycle, Load wins.

Top module: `fetch_fault_tracker`

## Requirements
- R1: While `rst_n` is low, `abort_take`, `debug_enter` and `ret_addr` are all zero, and any marks held in either slot are discarded. After release, completing or advancing the pipeline produces no pulse from marks that were present before reset.
- R2: A marked instruction loaded into decode, or moved into execute, produces no pulse until `ex_go` is asserted while it sits in execute.
- R3: A fetch-faulted instruction completing in execute gives `abort_take` high for exactly the cycle after the `ex_go` edge, with `ret_addr` equal to its address plus 4.
- R4: The abort of R3 is raised even when `cond_pass` is low in the completing cycle.
- R5: `flush` clears the decode slot and blocks that cycle's decode-to-execute load. `flush` wins over a simultaneous `dec_load`. It leaves the execute slot untouched.
- R6: While neither stage advances, the mark stays with its instruction in its slot and is acted on once the instruction later completes.
- R7: A breakpoint (flag `fe_bkpt`, with `fe_fault` low) completing in execute while `halt_dbg_en` is low raises `abort_take` with `ret_addr` equal to its address plus 4.
- R8: A breakpoint completing while `halt_dbg_en` is high raises `debug_enter` instead of `abort_take`. An instruction with `fe_fault` set always raises `abort_take`, even if its breakpoint flag is also set.
- R9: There is at most one pulse per marked instruction, and `abort_take` and `debug_enter` are never high together. An execute occupant that is replaced by a load without completing raises nothing. Back-to-back marked instructions each raise their own pulse.
- R10: `ret_addr` is zero in every cycle without a pulse, including after an unmarked instruction completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fe_valid | input | 1 | Fetched instruction present |
| fe_fault | input | 1 | Fetch reported a fault for this instruction |
| fe_bkpt | input | 1 | Fetched opcode is a breakpoint |
| fe_addr | input | AW | Address of the fetched instruction |
| dec_load | input | 1 | Decode slot loads from fetch |
| ex_load | input | 1 | Execute slot loads from decode |
| ex_go | input | 1 | Execute occupant completes this cycle |
| flush | input | 1 | Taken-branch flush of the decode slot |
| cond_pass | input | 1 | Condition result of the execute occupant |
| halt_dbg_en | input | 1 | Halting debug enabled |
| abort_take | output | 1 | Prefetch abort raised (one cycle) |
| debug_enter | output | 1 | Debug entry raised (one cycle) |
| ret_addr | output | AW | Faulting address plus 4 with a pulse, else zero |

## Verification
The bound checker verifies four properties on every cycle:
- The two pulses are never high together, and a pulse is never repeated unless a new instruction was loaded.
- A pulse always follows a completion, and debug entry always follows an enabled debug input.
- A faulted instruction whose condition fails still aborts.
- A flush into an empty execute slot cannot produce a pulse.

The remaining behaviours can only be shown by the bench scenarios. These cover the exact return address, marks held through stalls, a replaced occupant staying silent, fault priority over breakpoint, and reset discarding marks already in flight.

// File: rtl/ftrk_pkg.sv
package ftrk_pkg;

    // Execute slot occupancy classes
    typedef enum logic [1:0] {
        EX_EMPTY = 2'd0,
        EX_CLEAN = 2'd1,
        EX_FAULT = 2'd2,
        EX_BRK   = 2'd3
    } ex_state_e;

    // Offset added to the faulting address for the return address
    localparam int unsigned RET_OFS = 4;

    // Class of an instruction entering execute; fault outranks breakpoint
    function automatic ex_state_e classify(input logic vld, input logic flt, input logic bkpt);
        if (!vld)      return EX_EMPTY;
        else if (flt)  return EX_FAULT;
        else if (bkpt) return EX_BRK;
        else           return EX_CLEAN;
    endfunction

endpackage

// File: rtl/ftrk_dec_slot.sv
module ftrk_dec_slot #(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          dec_load,
    input  logic          ex_load,
    input  logic          fe_valid,
    input  logic          fe_fault,
    input  logic          fe_bkpt,
    input  logic [AW-1:0] fe_addr,
    output logic          dec_vld,
    output logic          dec_flt,
    output logic          dec_bkpt,
    output logic [AW-1:0] dec_addr
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dec_vld  <= 1'b0;
            dec_flt  <= 1'b0;
            dec_bkpt <= 1'b0;
            dec_addr <= '0;
        end else if (flush) begin
            dec_vld  <= 1'b0;
            dec_flt  <= 1'b0;
            dec_bkpt <= 1'b0;
        end else if (dec_load) begin
            dec_vld  <= fe_valid;
            dec_flt  <= fe_valid & fe_fault;
            dec_bkpt <= fe_valid & fe_bkpt;
            dec_addr <= fe_addr;
        end else if (ex_load) begin
            dec_vld  <= 1'b0;
            dec_flt  <= 1'b0;
            dec_bkpt <= 1'b0;
        end
    end

endmodule

// File: rtl/ftrk_ex_fsm.sv
module ftrk_ex_fsm
    import ftrk_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  ex_state_e     in_kind,
    input  logic [AW-1:0] in_addr,
    input  logic          ex_go,
    input  logic          halt_dbg_en,
    output ex_state_e     state,
    output logic          abort_take,
    output logic          debug_enter,
    output logic [AW-1:0] ret_addr
);

    ex_state_e     state_nx;
    logic [AW-1:0] ex_addr;
    logic          fire_abt;
    logic          fire_dbg;

    // Next state: completion empties the slot, a load overrides it
    always_comb begin
        state_nx = state;
        unique case (state)
            EX_EMPTY: state_nx = EX_EMPTY;
            EX_CLEAN,
            EX_FAULT,
            EX_BRK:   if (ex_go) state_nx = EX_EMPTY;
            default:  state_nx = EX_EMPTY;
        endcase
        if (load) state_nx = in_kind;
    end

    always_comb begin
        fire_abt = 1'b0;
        fire_dbg = 1'b0;
        unique case (state)
            EX_FAULT: fire_abt = ex_go;
            EX_BRK: begin
                fire_abt = ex_go & ~halt_dbg_en;
                fire_dbg = ex_go &  halt_dbg_en;
            end
            default: ;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= EX_EMPTY;
            ex_addr <= '0;
        end else begin
            state <= state_nx;
            if (load) ex_addr <= in_addr;
        end
    end

    // Registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            abort_take  <= 1'b0;
            debug_enter <= 1'b0;
            ret_addr    <= '0;
        end else begin
            abort_take  <= fire_abt;
            debug_enter <= fire_dbg;
            ret_addr    <= (fire_abt | fire_dbg) ? ex_addr + AW'(RET_OFS) : '0;
        end
    end

endmodule

// File: rtl/fetch_fault_tracker.sv
module fetch_fault_tracker
    import ftrk_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fe_valid,
    input  logic          fe_fault,
    input  logic          fe_bkpt,
    input  logic [AW-1:0] fe_addr,
    input  logic          dec_load,
    input  logic          ex_load,
    input  logic          ex_go,
    input  logic          flush,
    input  logic          cond_pass,
    input  logic          halt_dbg_en,
    output logic          abort_take,
    output logic          debug_enter,
    output logic [AW-1:0] ret_addr
);

    logic          dec_vld;
    logic          dec_flt;
    logic          dec_bkpt;
    logic [AW-1:0] dec_addr;
    logic          ex_take;
    ex_state_e     ex_kind;
    ex_state_e     ex_state;

    // Flushed decode contents never reach execute
    assign ex_take = ex_load & ~flush;
    assign ex_kind = classify(dec_vld, dec_flt, dec_bkpt);

    ftrk_dec_slot #(.AW(AW)) u_dec (
        .clk      (clk),
        .rst_n    (rst_n),
        .flush    (flush),
        .dec_load (dec_load),
        .ex_load  (ex_load),
        .fe_valid (fe_valid),
        .fe_fault (fe_fault),
        .fe_bkpt  (fe_bkpt),
        .fe_addr  (fe_addr),
        .dec_vld  (dec_vld),
        .dec_flt  (dec_flt),
        .dec_bkpt (dec_bkpt),
        .dec_addr (dec_addr)
    );

    ftrk_ex_fsm #(.AW(AW)) u_ex (
        .clk         (clk),
        .rst_n       (rst_n),
        .load        (ex_take),
        .in_kind     (ex_kind),
        .in_addr     (dec_addr),
        .ex_go       (ex_go),
        .halt_dbg_en (halt_dbg_en),
        .state       (ex_state),
        .abort_take  (abort_take),
        .debug_enter (debug_enter),
        .ret_addr    (ret_addr)
    );

endmodule

// File: rtl/ftrk_checker.sv
module ftrk_checker
    import ftrk_pkg::*;
(
    input logic      clk,
    input logic      rst_n,
    input logic      flush,
    input logic      ex_load,
    input logic      ex_go,
    input logic      cond_pass,
    input logic      halt_dbg_en,
    input ex_state_e ex_state,
    input logic      abort_take,
    input logic      debug_enter
);

    logic pulse;
    assign pulse = abort_take | debug_enter;

    a_r9_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({abort_take, debug_enter}));

    a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        pulse && !$past(ex_load) |=> !pulse);

    a_r2_needs_completion: assert property (@(posedge clk) disable iff (!rst_n)
        pulse |-> $past(ex_go));

    a_r4_cond_fail_aborts: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_state == EX_FAULT) && ex_go && !cond_pass |=> abort_take);

    a_r5_flush_silent: assert property (@(posedge clk) disable iff (!rst_n)
        flush && (ex_state == EX_EMPTY) |=> ##1 !pulse);

    a_r8_debug_enabled: assert property (@(posedge clk) disable iff (!rst_n)
        debug_enter |-> $past(halt_dbg_en));

endmodule

bind fetch_fault_tracker ftrk_checker u_ftrk_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .flush       (flush),
    .ex_load     (ex_load),
    .ex_go       (ex_go),
    .cond_pass   (cond_pass),
    .halt_dbg_en (halt_dbg_en),
    .ex_state    (ex_state),
    .abort_take  (abort_take),
    .debug_enter (debug_enter)
);

// File: tb/fetch_fault_tracker_bench.sv
module fetch_fault_tracker_bench;

    localparam int CLK_PERIOD = 10;
    localparam int AW = 32;
    localparam bit H = 1'b1;
    localparam bit L = 1'b0;

    typedef struct packed {
        logic          v, f, b;
        logic [31:0]   a;
        logic          dl, el, eg, fl, cp, dbg;
        logic          ea, ed;
        logic [31:0]   ex;
        logic [3:0]    rq;
    } vec_t;

    localparam int NV = 38;
    localparam vec_t TBL [NV] = '{
        // R2/R3/R9: fault at 0x100
        '{H,H,L,32'h100, H,L,L,L,H,L, L,L,32'h0,   4'd2},
        '{L,L,L,32'h0,   L,H,L,L,H,L, L,L,32'h0,   4'd2},
        '{L,L,L,32'h0,   L,L,H,L,H,L, H,L,32'h104, 4'd3},
        '{L,L,L,32'h0,   L,L,L,L,H,L, L,L,32'h0,   4'd9},
        // R4: condition fails, still aborts
        '{H,H,L,32'h200, H,L,L,L,H,L, L,L,32'h0,   4'd2},
        '{L,L,L,32'h0,   L,H,L,L,H,L, L,L,32'h0,   4'd2},
        '{L,L,L,32'h0,   L,L,H,L,L,L, H,L,32'h204, 4'd4},
        // R5: flush drops decode tag
        '{H,H,L,32'h300, H,L,L,L,H,L, L,L,32'h0,   4'd5},
        '{L,L,L,32'h0,   L,H,L,H,H,L, L,L,32'h0,   4'd5},
        '{L,L,L,32'h0,   L,L,H,L,H,L, L,L,32'h0,   4'd5},
        // R7: breakpoint, debug off
        '{H,L,H,32'h400, H,L,L,L,H,L, L,L,32'h0,   4'd7},
        '{L,L,L,32'h0,   L,H,L,L,H,L, L,L,32'h0,   4'd7},
        '{L,L,L,32'h0,   L,L,H,L,H,L, H,L,32'h404, 4'd7},
        // R8: breakpoint, debug on
        '{H,L,H,32'h500, H,L,L,L,H,L, L,L,32'h0,   4'd8},
        '{L,L,L,32'h0,   L,H,L,L,H,L, L,L,32'h0,   4'd8},
        '{L,L,L,32'h0,   L,L,H,L,H,H, L,H,32'h504, 4'd8},
        // R8: fault plus breakpoint, debug on -> abort
        '{H,H,H,32'h600, H,L,L,L,H,L, L,L,32'h0,   4'd8},
        '{L,L,L,32'h0,   L,H,L,L,H,L, L,L,32'h0,   4'd8},
        '{L,L,L,32'h0,   L,L,H,L,H,H, H,L,32'h604, 4'd8},
        // R6: stalls in both slots
        '{H,H,L,32'h700, H,L,L,L,H,L, L,L,32'h0,   4'd6},
        '{L,L,L,32'h0,   L,L,L,L,H,L, L,L,32'h0,   4'd6},
        '{L,L,L,32'h0,   L,L,L,L,H,L, L,L,32'h0,   4'd6},
        '{L,L,L,32'h0,   L,H,L,L,H,L, L,L,32'h0,   4'd6},
        '{L,L,L,32'h0,   L,L,L,L,H,L, L,L,32'h0,   4'd6},
        '{L,L,L,32'h0,   L,L,L,L,H,L, L,L,32'h0,   4'd6},
        '{L,L,L,32'h0,   L,L,H,L,H,L, H,L,32'h704, 4'd6},
        // R10: clean instruction
        '{H,L,L,32'h800, H,L,L,L,H,L, L,L,32'h0,   4'd10},
        '{L,L,L,32'h0,   L,H,L,L,H,L, L,L,32'h0,   4'd10},
        '{L,L,L,32'h0,   L,L,H,L,H,L, L,L,32'h0,   4'd10},
        // R9: execute occupant replaced without completing
        '{H,H,L,32'h900, H,L,L,L,H,L, L,L,32'h0,   4'd9},
        '{L,L,L,32'h0,   L,H,L,L,H,L, L,L,32'h0,   4'd9},
        '{L,L,L,32'h0,   L,H,L,L,H,L, L,L,32'h0,   4'd9},
        '{L,L,L,32'h0,   L,L,H,L,H,L, L,L,32'h0,   4'd9},
        // R9/R7: back-to-back fault then breakpoint
        '{H,H,L,32'hA00, H,L,L,L,H,L, L,L,32'h0,   4'd9},
        '{H,L,H,32'hB00, H,H,L,L,H,L, L,L,32'h0,   4'd9},
        '{L,L,L,32'h0,   L,H,H,L,H,L, H,L,32'hA04, 4'd9},
        '{L,L,L,32'h0,   L,L,H,L,H,L, H,L,32'hB04, 4'd7},
        '{L,L,L,32'h0,   L,L,L,L,H,L, L,L,32'h0,   4'd9}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          fe_valid = 1'b0, fe_fault = 1'b0, fe_bkpt = 1'b0;
    logic [AW-1:0] fe_addr = '0;
    logic          dec_load = 1'b0, ex_load = 1'b0, ex_go = 1'b0, flush = 1'b0;
    logic          cond_pass = 1'b1, halt_dbg_en = 1'b0;
    logic          abort_take, debug_enter;
    logic [AW-1:0] ret_addr;

    int checks = 0;
    int failures = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fetch_fault_tracker #(.AW(AW)) u_fetch_fault_tracker (
        .clk         (clk),
        .rst_n       (rst_n),
        .fe_valid    (fe_valid),
        .fe_fault    (fe_fault),
        .fe_bkpt     (fe_bkpt),
        .fe_addr     (fe_addr),
        .dec_load    (dec_load),
        .ex_load     (ex_load),
        .ex_go       (ex_go),
        .flush       (flush),
        .cond_pass   (cond_pass),
        .halt_dbg_en (halt_dbg_en),
        .abort_take  (abort_take),
        .debug_enter (debug_enter),
        .ret_addr    (ret_addr)
    );

    task automatic drive(input logic v, input logic f, input logic b, input logic [31:0] a,
                         input logic dl, input logic el, input logic eg, input logic fl,
                         input logic cp, input logic dbg);
        @(negedge clk);
        fe_valid = v; fe_fault = f; fe_bkpt = b; fe_addr = a;
        dec_load = dl; ex_load = el; ex_go = eg; flush = fl;
        cond_pass = cp; halt_dbg_en = dbg;
    endtask

    task automatic sample(input logic ea, input logic ed, input logic [31:0] ex, input int rq);
        @(posedge clk);
        #2;
        checks++;
        if (abort_take !== ea || debug_enter !== ed || ret_addr !== ex) begin
            failures++;
            $display("FAIL R%0d: abort_take=%0b debug_enter=%0b ret_addr=%h expected %0b %0b %h",
                     rq, abort_take, debug_enter, ret_addr, ea, ed, ex);
        end
    endtask

    task automatic step(input logic v, input logic f, input logic b, input logic [31:0] a,
                        input logic dl, input logic el, input logic eg, input logic fl,
                        input logic ea, input logic [31:0] ex, input int rq);
        drive(v, f, b, a, dl, el, eg, fl, 1'b1, 1'b0);
        sample(ea, 1'b0, ex, rq);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        failures++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        // R1: outputs idle while reset is held
        sample(1'b0, 1'b0, 32'h0, 1);
        sample(1'b0, 1'b0, 32'h0, 1);
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            drive(TBL[i].v, TBL[i].f, TBL[i].b, TBL[i].a, TBL[i].dl, TBL[i].el,
                  TBL[i].eg, TBL[i].fl, TBL[i].cp, TBL[i].dbg);
            sample(TBL[i].ea, TBL[i].ed, TBL[i].ex, int'(TBL[i].rq));
        end

        // R5: flush beats a same-cycle decode load
        step(H,H,L,32'hE00, H,L,L,H, L,32'h0, 5);
        step(L,L,L,32'h0,   L,H,L,L, L,32'h0, 5);
        step(L,L,L,32'h0,   L,L,H,L, L,32'h0, 5);

        // R5: flush leaves the execute slot alone
        step(H,H,L,32'hF00, H,L,L,L, L,32'h0, 5);
        step(L,L,L,32'h0,   L,H,L,L, L,32'h0, 5);
        step(L,L,L,32'h0,   L,L,L,H, L,32'h0, 5);
        step(L,L,L,32'h0,   L,L,H,L, H,32'hF04, 5);
        step(L,L,L,32'h0,   L,L,L,L, L,32'h0, 9);

        // R1: reset discards marks in flight
        step(H,H,L,32'hC00, H,L,L,L, L,32'h0, 1);
        step(H,H,L,32'hD00, H,H,L,L, L,32'h0, 1);
        @(negedge clk);
        rst_n = 1'b0;
        fe_valid = 1'b0; dec_load = 1'b0; ex_load = 1'b0; ex_go = 1'b0;
        sample(1'b0, 1'b0, 32'h0, 1);
        @(negedge clk);
        rst_n = 1'b1;
        step(L,L,L,32'h0, L,L,H,L, L,32'h0, 1);
        step(L,L,L,32'h0, L,H,L,L, L,32'h0, 1);
        step(L,L,L,32'h0, L,L,H,L, L,32'h0, 1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule